// File: doc/BRIEF.md
# Authenticated Cipher Input Segment Parser

This block stands between two input word queues and the datapath of an authenticated cipher. One queue holds public words (instruction, nonce, associated data, plaintext or ciphertext, tag) and the other holds secret words (instruction and key). Each queue offers a word with a ready line, and the block takes it with a read strobe. Each stream has its own parser. A parser first decodes an instruction word, then a series of typed headers. Each header carries a byte length, and the parser forwards the payload words that follow it to the core. Every forwarded word is labelled with its segment type and with end-of-segment and last-segment markers.

Each parser is a three-state machine. IDLE_INSTR waits for an instruction word. On a valid opcode it takes the transition "accept instruction" to AWAIT_HDR. On a bad opcode it takes "reject" and stays in IDLE_INSTR. AWAIT_HDR checks the header. A header with a nonzero length takes "open segment" to STREAM_PAYLOAD. A zero-length header takes "skip segment" and stays in AWAIT_HDR, or returns to IDLE_INSTR when the segment was the final one. A bad header takes "abort" back to IDLE_INSTR. STREAM_PAYLOAD counts the payload words down. On the final word it takes "close segment" to AWAIT_HDR, or "close input" to IDLE_INSTR after the final segment.

Malformed input produces a one-cycle pulse on a shared error output, together with an 8-bit code. The code says what went wrong and on which stream.

Top module: `aead_seg_parser`

## Requirements
- R1: A word is consumed only on a rising clock edge where the port's ready and read are both high. Both read strobes are low while rst_n is low, and they stay high from the first clock edge after reset.
- R2: The instruction opcode is held in bits [W-1:W-4]. On the public stream, 0010 selects encryption and 0011 selects decryption. On the secret stream, 0100 selects key loading. Any other opcode raises error code 0x01 on the public stream or 0x81 on the secret stream.
- R3: A header holds its fields in these bit positions: an identifier in [W-1:W-8], the segment type in [W-9:W-12], two spare bits in [W-13:W-14], a flag in [W-15], the last-segment flag in [W-16], and the byte length in [W-17:0]. The identifier, the spare bits and the flag are not interpreted.
- R4: After a header, the parser reads ceil(length*8/W) payload words. When the length is zero, the next word is treated as the following header.
- R5: Each consumed payload word appears on the stream's output one clock after it is consumed. It comes with valid high and carries the segment type: 1 IV, 2 associated data, 3 message, 4 ciphertext, 5 tag, 6 key.
- R6: The end-of-segment marker is high only on a segment's final payload word. The last marker equals the header's last-segment flag on that word and is 0 on every other word.
- R7: The expected segment order is IV, AD, MSG for encryption; IV, AD, CT, TAG for decryption; and KEY on the secret stream.
- R8: A header whose type is 0 or 7 to 15 raises code 0x02 (public) or 0x82 (secret) and returns the parser to waiting for an instruction.
- R9: A legal type that is not the next one in the expected order raises code 0x03 (public) or 0x83 (secret) and returns the parser to waiting for an instruction.
- R10: A last-segment flag that is set on a segment other than the final expected one, or clear on the final one, raises code 0x04 (public) or 0x84 (secret).
- R11: The error output is a one-cycle pulse that comes one clock after the offending word is consumed, and err_code is 0 whenever the error output is low. If both streams fail in the same cycle, the public code is reported.
- R12: After the final segment's last payload word, or after any error, the very next consumed word is decoded as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pub_data | input | W | Public stream word |
| pub_ready | input | 1 | Public word available |
| pub_read | output | 1 | Public read strobe |
| sec_data | input | W | Secret stream word |
| sec_ready | input | 1 | Secret word available |
| sec_read | output | 1 | Secret read strobe |
| pub_valid | output | 1 | Public payload word valid |
| pub_word | output | W | Public payload word |
| pub_type | output | 4 | Segment type of public word |
| pub_eos | output | 1 | Final word of public segment |
| pub_last | output | 1 | Final word of final public segment |
| sec_valid | output | 1 | Secret payload word valid |
| sec_word | output | W | Secret payload word |
| sec_type | output | 4 | Segment type of secret word |
| sec_eos | output | 1 | Final word of secret segment |
| sec_last | output | 1 | Final word of final secret segment |
| err | output | 1 | Error pulse |
| err_code | output | 8 | Error code, bit 7 marks the secret stream |

## Verification
The bench sends zero-length segments in the middle and at the end of an input. A parser that fails to skip them would swallow the next header as payload. It also sends lengths that are not a multiple of the word size, and the largest length the field can hold. A wrong rounding would forward one word too many or too few, and the queue of expected words would then go out of step. It holds ready low with junk data during a payload, which exposes a parser that consumes words without the handshake. Error cases cover bad opcodes, reserved types, out-of-order types, misplaced last flags and simultaneous faults on both streams. A parser that failed to return to instruction wait after an error would reject or misroute the clean traffic that follows.

// File: rtl/asp_pkg.sv
package asp_pkg;

    typedef enum logic [1:0] {
        IDLE_INSTR,
        AWAIT_HDR,
        STREAM_PAYLOAD
    } pstate_t;

    typedef enum logic [1:0] {
        MODE_ENC,
        MODE_DEC,
        MODE_KEY
    } pmode_t;

    localparam logic [3:0] SEG_IV  = 4'd1;
    localparam logic [3:0] SEG_AD  = 4'd2;
    localparam logic [3:0] SEG_MSG = 4'd3;
    localparam logic [3:0] SEG_CT  = 4'd4;
    localparam logic [3:0] SEG_TAG = 4'd5;
    localparam logic [3:0] SEG_KEY = 4'd6;

    localparam logic [3:0] OP_ENC = 4'h2;
    localparam logic [3:0] OP_DEC = 4'h3;
    localparam logic [3:0] OP_KEY = 4'h4;

    localparam logic [6:0] FAULT_OPCODE   = 7'h01;
    localparam logic [6:0] FAULT_RESERVED = 7'h02;
    localparam logic [6:0] FAULT_ORDER    = 7'h03;
    localparam logic [6:0] FAULT_LASTFLAG = 7'h04;

    // Segment type expected at a given position of a given mode
    function automatic logic [3:0] seg_expected(pmode_t m, logic [1:0] s);
        logic [3:0] t;
        case (m)
            MODE_ENC: t = (s == 2'd0) ? SEG_IV : (s == 2'd1) ? SEG_AD : SEG_MSG;
            MODE_DEC: t = (s == 2'd0) ? SEG_IV : (s == 2'd1) ? SEG_AD :
                          (s == 2'd2) ? SEG_CT : SEG_TAG;
            default:  t = SEG_KEY;
        endcase
        return t;
    endfunction

    // Position of the final segment in a mode
    function automatic logic [1:0] seg_final(pmode_t m);
        logic [1:0] f;
        case (m)
            MODE_ENC: f = 2'd2;
            MODE_DEC: f = 2'd3;
            default:  f = 2'd0;
        endcase
        return f;
    endfunction

    function automatic logic seg_reserved(logic [3:0] t);
        return (t == 4'd0) || (t > SEG_KEY);
    endfunction

endpackage

// File: rtl/asp_beats.sv
module asp_beats #(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    input  logic [W-17:0] len,
    output logic          none,
    output logic          final_beat
);
    localparam int LW = W - 16;
    localparam int CW = LW + 4;

    logic [CW-1:0] scaled;
    logic [CW-1:0] beats;
    logic [CW-1:0] rem;

    always_comb begin
        scaled     = {1'b0, len, 3'b000} + CW'(W - 1);
        beats      = scaled / CW'(W);
        none       = (beats == '0);
        final_beat = (rem == CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (load) begin
            rem <= beats;
        end else if (dec) begin
            rem <= rem - CW'(1);
        end
    end
endmodule

// File: rtl/asp_stream.sv
module asp_stream
    import asp_pkg::*;
#(
    parameter int W         = 32,
    parameter bit IS_SECRET = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_ready,
    output logic         in_read,
    output logic         o_valid,
    output logic [W-1:0] o_data,
    output logic [3:0]   o_type,
    output logic         o_eos,
    output logic         o_last,
    output logic         e_valid,
    output logic [7:0]   e_code
);
    localparam logic [7:0] SRC_BIT = IS_SECRET ? 8'h80 : 8'h00;

    pstate_t    state, nstate;
    pmode_t     mode, nmode;
    logic [1:0] step, nstep;
    logic [3:0] cur_type, ntype;
    logic       cur_last, nlast;
    logic       rd_en;

    logic       fire;
    logic [3:0] op, htype;
    logic       hlast;
    logic       op_ok;
    pmode_t     op_mode;
    logic       is_final;
    logic       err_now;
    logic [6:0] err_sel;
    logic       cnt_load, cnt_dec;
    logic       zero_len, last_beat;

    assign in_read = rd_en;
    assign fire    = in_ready & rd_en;
    assign op      = in_data[W-1 -: 4];
    assign htype   = in_data[W-9 -: 4];
    assign hlast   = in_data[W-16];

    generate
        if (IS_SECRET) begin : g_secret_ops
            always_comb begin
                op_ok   = (op == OP_KEY);
                op_mode = MODE_KEY;
            end
        end else begin : g_public_ops
            always_comb begin
                op_ok   = (op == OP_ENC) || (op == OP_DEC);
                op_mode = (op == OP_DEC) ? MODE_DEC : MODE_ENC;
            end
        end
    endgenerate

    asp_beats #(.W(W)) u_beats (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cnt_load),
        .dec        (cnt_dec),
        .len        (in_data[W-17:0]),
        .none       (zero_len),
        .final_beat (last_beat)
    );

    assign is_final = (step == seg_final(mode));

    always_comb begin
        nstate   = state;
        nmode    = mode;
        nstep    = step;
        ntype    = cur_type;
        nlast    = cur_last;
        err_now  = 1'b0;
        err_sel  = '0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        if (fire) begin
            unique case (state)
                IDLE_INSTR: begin
                    if (op_ok) begin
                        nmode  = op_mode;
                        nstep  = 2'd0;
                        nstate = AWAIT_HDR;
                    end else begin
                        err_now = 1'b1;
                        err_sel = FAULT_OPCODE;
                    end
                end
                AWAIT_HDR: begin
                    if (seg_reserved(htype)) begin
                        err_now = 1'b1;
                        err_sel = FAULT_RESERVED;
                        nstate  = IDLE_INSTR;
                    end else if (htype != seg_expected(mode, step)) begin
                        err_now = 1'b1;
                        err_sel = FAULT_ORDER;
                        nstate  = IDLE_INSTR;
                    end else if (hlast != is_final) begin
                        err_now = 1'b1;
                        err_sel = FAULT_LASTFLAG;
                        nstate  = IDLE_INSTR;
                    end else begin
                        ntype = htype;
                        nlast = hlast;
                        if (!zero_len) begin
                            cnt_load = 1'b1;
                            nstate   = STREAM_PAYLOAD;
                        end else if (is_final) begin
                            nstate = IDLE_INSTR;
                        end else begin
                            nstep = step + 2'd1;
                        end
                    end
                end
                STREAM_PAYLOAD: begin
                    cnt_dec = 1'b1;
                    if (last_beat) begin
                        if (is_final) begin
                            nstate = IDLE_INSTR;
                        end else begin
                            nstep  = step + 2'd1;
                            nstate = AWAIT_HDR;
                        end
                    end
                end
                default: nstate = IDLE_INSTR;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= IDLE_INSTR;
            mode     <= MODE_ENC;
            step     <= 2'd0;
            cur_type <= 4'd0;
            cur_last <= 1'b0;
            rd_en    <= 1'b0;
        end else begin
            state    <= nstate;
            mode     <= nmode;
            step     <= nstep;
            cur_type <= ntype;
            cur_last <= nlast;
            rd_en    <= 1'b1;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_data  <= '0;
            o_type  <= 4'd0;
            o_eos   <= 1'b0;
            o_last  <= 1'b0;
            e_valid <= 1'b0;
            e_code  <= 8'h00;
        end else begin
            o_valid <= fire && (state == STREAM_PAYLOAD);
            o_data  <= in_data;
            o_type  <= cur_type;
            o_eos   <= fire && (state == STREAM_PAYLOAD) && last_beat;
            o_last  <= fire && (state == STREAM_PAYLOAD) && last_beat && cur_last;
            e_valid <= err_now;
            e_code  <= err_now ? (SRC_BIT | {1'b0, err_sel}) : 8'h00;
        end
    end
endmodule

// File: rtl/asp_err_merge.sv
module asp_err_merge (
    input  logic       p_valid,
    input  logic [7:0] p_code,
    input  logic       s_valid,
    input  logic [7:0] s_code,
    output logic       err,
    output logic [7:0] err_code
);
    always_comb begin
        err      = p_valid | s_valid;
        err_code = p_valid ? p_code : (s_valid ? s_code : 8'h00);
    end
endmodule

// File: rtl/aead_seg_parser.sv
module aead_seg_parser #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pub_data,
    input  logic         pub_ready,
    output logic         pub_read,
    input  logic [W-1:0] sec_data,
    input  logic         sec_ready,
    output logic         sec_read,
    output logic         pub_valid,
    output logic [W-1:0] pub_word,
    output logic [3:0]   pub_type,
    output logic         pub_eos,
    output logic         pub_last,
    output logic         sec_valid,
    output logic [W-1:0] sec_word,
    output logic [3:0]   sec_type,
    output logic         sec_eos,
    output logic         sec_last,
    output logic         err,
    output logic [7:0]   err_code
);
    logic       p_err, s_err;
    logic [7:0] p_code, s_code;

    asp_stream #(.W(W), .IS_SECRET(1'b0)) u_pub (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (pub_data),
        .in_ready (pub_ready),
        .in_read  (pub_read),
        .o_valid  (pub_valid),
        .o_data   (pub_word),
        .o_type   (pub_type),
        .o_eos    (pub_eos),
        .o_last   (pub_last),
        .e_valid  (p_err),
        .e_code   (p_code)
    );

    asp_stream #(.W(W), .IS_SECRET(1'b1)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (sec_data),
        .in_ready (sec_ready),
        .in_read  (sec_read),
        .o_valid  (sec_valid),
        .o_data   (sec_word),
        .o_type   (sec_type),
        .o_eos    (sec_eos),
        .o_last   (sec_last),
        .e_valid  (s_err),
        .e_code   (s_code)
    );

    asp_err_merge u_merge (
        .p_valid  (p_err),
        .p_code   (p_code),
        .s_valid  (s_err),
        .s_code   (s_code),
        .err      (err),
        .err_code (err_code)
    );
endmodule

// File: rtl/asp_checker.sv
module asp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pub_ready,
    input logic       pub_read,
    input logic       sec_ready,
    input logic       sec_read,
    input logic       pub_valid,
    input logic [3:0] pub_type,
    input logic       pub_eos,
    input logic       pub_last,
    input logic       sec_valid,
    input logic [3:0] sec_type,
    input logic       sec_eos,
    input logic       sec_last,
    input logic       err,
    input logic [7:0] err_code
);
    assert_pub_consumed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pub_valid |-> $past(pub_ready && pub_read));

    assert_sec_consumed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> $past(sec_ready && sec_read));

    assert_read_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pub_read) |-> (pub_read && sec_read));

    assert_pub_type_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pub_valid |-> (pub_type inside {[4'd1:4'd6]}));

    assert_sec_type_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> (sec_type == 4'd6));

    assert_pub_last_in_eos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pub_last |-> (pub_eos && pub_valid));

    assert_sec_last_in_eos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_last |-> (sec_eos && sec_valid));

    assert_code_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 8'h00));

    assert_code_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> (err_code == 8'h00));

    assert_pub_abort_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_code[7]) |=> !pub_valid);
endmodule

bind aead_seg_parser asp_checker u_chk (.*);

// File: tb/sim_aead_seg_parser.sv
module sim_aead_seg_parser;
    localparam int W = 32;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [W-1:0] d;
        logic [3:0]   t;
        logic         eos;
        logic         last;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] pub_data, sec_data;
    logic         pub_ready, sec_ready;
    logic         pub_read, sec_read;
    logic         pub_valid, sec_valid;
    logic [W-1:0] pub_word, sec_word;
    logic [3:0]   pub_type, sec_type;
    logic         pub_eos, sec_eos, pub_last, sec_last;
    logic         err;
    logic [7:0]   err_code;

    aead_seg_parser #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .pub_data(pub_data), .pub_ready(pub_ready), .pub_read(pub_read),
        .sec_data(sec_data), .sec_ready(sec_ready), .sec_read(sec_read),
        .pub_valid(pub_valid), .pub_word(pub_word), .pub_type(pub_type),
        .pub_eos(pub_eos), .pub_last(pub_last),
        .sec_valid(sec_valid), .sec_word(sec_word), .sec_type(sec_type),
        .sec_eos(sec_eos), .sec_last(sec_last),
        .err(err), .err_code(err_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    item_t pub_q[$];
    item_t sec_q[$];
    string pub_tag_q[$];
    string sec_tag_q[$];
    logic [7:0] err_q[$];
    string err_tag_q[$];

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] hdr(logic [3:0] t, bit last, logic [15:0] len);
        return {8'hA5, t, 2'b00, 1'b0, last, len};
    endfunction

    function automatic logic [W-1:0] instr(logic [3:0] op);
        return {op, 28'h0};
    endfunction

    task automatic put_pub(logic [W-1:0] d);
        pub_data  = d;
        pub_ready = 1'b1;
        @(negedge clk);
        pub_ready = 1'b0;
        pub_data  = '0;
    endtask

    task automatic put_sec(logic [W-1:0] d);
        sec_data  = d;
        sec_ready = 1'b1;
        @(negedge clk);
        sec_ready = 1'b0;
        sec_data  = '0;
    endtask

    task automatic exp_err(logic [7:0] c, string tag);
        err_q.push_back(c);
        err_tag_q.push_back(tag);
    endtask

    // Drives a header and its payload, pushing the expected forwarded words
    task automatic pub_seg(logic [3:0] t, int len, bit last, string tag, int gap_at);
        int nb;
        put_pub(hdr(t, last, 16'(len)));
        nb = (len * 8 + W - 1) / W;
        for (int i = 0; i < nb; i++) begin
            item_t e;
            e.d    = {t, 12'h3C5, 16'(i)} ^ 32'(len);
            e.t    = t;
            e.eos  = (i == nb - 1);
            e.last = (i == nb - 1) && last;
            pub_q.push_back(e);
            pub_tag_q.push_back(tag);
            put_pub(e.d);
            if (i == gap_at) begin
                pub_data = 32'hDEADBEEF;
                repeat (2) @(negedge clk);
                pub_data = '0;
            end
        end
    endtask

    task automatic sec_seg(logic [3:0] t, int len, bit last, string tag);
        int nb;
        put_sec(hdr(t, last, 16'(len)));
        nb = (len * 8 + W - 1) / W;
        for (int i = 0; i < nb; i++) begin
            item_t e;
            e.d    = {t, 12'h9E1, 16'(i)} ^ 32'(len << 4);
            e.t    = t;
            e.eos  = (i == nb - 1);
            e.last = (i == nb - 1) && last;
            sec_q.push_back(e);
            sec_tag_q.push_back(tag);
            put_sec(e.d);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Monitor: compares outputs with the scoreboard queues
    always @(negedge clk) begin
        item_t e;
        item_t a;
        string tg;
        logic [7:0] ec;
        if (rst_n && !done) begin
            if (pub_valid) begin
                a = {pub_word, pub_type, pub_eos, pub_last};
                if (pub_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected public word", 64'(a), 64'(0));
                end else begin
                    e  = pub_q.pop_front();
                    tg = pub_tag_q.pop_front();
                    check(a == e, tg, "public word", 64'(a), 64'(e));
                end
            end
            if (sec_valid) begin
                a = {sec_word, sec_type, sec_eos, sec_last};
                if (sec_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected secret word", 64'(a), 64'(0));
                end else begin
                    e  = sec_q.pop_front();
                    tg = sec_tag_q.pop_front();
                    check(a == e, tg, "secret word", 64'(a), 64'(e));
                end
            end
            if (err) begin
                if (err_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected error", 64'(err_code), 64'(0));
                end else begin
                    ec = err_q.pop_front();
                    tg = err_tag_q.pop_front();
                    check(err_code == ec, tg, "error code", 64'(err_code), 64'(ec));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog run hung actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pub_ready = 1'b0; sec_ready = 1'b0;
        pub_data = '0; sec_data = '0;
        repeat (3) @(negedge clk);
        check(pub_read == 1'b0, "R1", "public read in reset", 64'(pub_read), 64'(0));
        check(sec_read == 1'b0, "R1", "secret read in reset", 64'(sec_read), 64'(0));
        check(pub_valid == 1'b0, "R5", "valid in reset", 64'(pub_valid), 64'(0));
        check(err == 1'b0 && err_code == 8'h00, "R11", "error in reset", 64'(err_code), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(pub_read == 1'b1, "R1", "public read after reset", 64'(pub_read), 64'(1));
        check(sec_read == 1'b1, "R1", "secret read after reset", 64'(sec_read), 64'(1));

        // R7 encryption order, R1 gap with junk data, R4 zero-length AD, R6 last
        put_pub(instr(4'h2));
        pub_seg(4'd1, 16, 1'b0, "R1", 1);
        pub_seg(4'd2, 0, 1'b0, "R4", -1);
        pub_seg(4'd3, 5, 1'b1, "R6", -1);

        // R12 next instruction directly after; R7 decryption order
        put_pub(instr(4'h3));
        pub_seg(4'd1, 12, 1'b0, "R12", -1);
        pub_seg(4'd2, 3, 1'b0, "R4", -1);
        pub_seg(4'd4, 8, 1'b0, "R7", -1);
        pub_seg(4'd5, 16, 1'b1, "R7", -1);

        // R3 R7 secret key
        put_sec(instr(4'h4));
        sec_seg(4'd6, 16, 1'b1, "R3");

        // R2 bad opcodes
        exp_err(8'h01, "R2");
        put_pub(instr(4'h7));
        exp_err(8'h81, "R2");
        put_sec(instr(4'h2));

        // R8 reserved types
        put_pub(instr(4'h2));
        exp_err(8'h02, "R8");
        put_pub(hdr(4'd0, 1'b0, 16'd4));
        put_sec(instr(4'h4));
        exp_err(8'h82, "R8");
        put_sec(hdr(4'd9, 1'b1, 16'd16));

        // R9 out of order
        put_pub(instr(4'h2));
        exp_err(8'h03, "R9");
        put_pub(hdr(4'd3, 1'b1, 16'd4));
        put_sec(instr(4'h4));
        exp_err(8'h83, "R9");
        put_sec(hdr(4'd1, 1'b1, 16'd16));

        // R10 last flag misplaced, both ways
        put_pub(instr(4'h2));
        exp_err(8'h04, "R10");
        put_pub(hdr(4'd1, 1'b1, 16'd16));
        put_pub(instr(4'h2));
        pub_seg(4'd1, 4, 1'b0, "R10", -1);
        pub_seg(4'd2, 4, 1'b0, "R10", -1);
        exp_err(8'h04, "R10");
        put_pub(hdr(4'd3, 1'b0, 16'd4));

        // R12 recovery after error, zero-length final message
        put_pub(instr(4'h2));
        pub_seg(4'd1, 4, 1'b0, "R12", -1);
        pub_seg(4'd2, 0, 1'b0, "R12", -1);
        pub_seg(4'd3, 0, 1'b1, "R4", -1);

        // R11 simultaneous faults: public code wins
        exp_err(8'h01, "R11");
        pub_data = instr(4'h7); sec_data = instr(4'h7);
        pub_ready = 1'b1; sec_ready = 1'b1;
        @(negedge clk);
        pub_ready = 1'b0; sec_ready = 1'b0;
        put_sec(instr(4'h4));
        sec_seg(4'd6, 3, 1'b1, "R11");

        // R4 largest length
        put_pub(instr(4'h2));
        pub_seg(4'd1, 0, 1'b0, "R4", -1);
        pub_seg(4'd2, 1, 1'b0, "R4", -1);
        pub_seg(4'd3, 65535, 1'b1, "R4", -1);

        repeat (4) @(negedge clk);
        done = 1'b1;
        check(pub_q.size() == 0, "R4", "public words missing", 64'(pub_q.size()), 64'(0));
        check(sec_q.size() == 0, "R4", "secret words missing", 64'(sec_q.size()), 64'(0));
        check(err_q.size() == 0, "R11", "errors missing", 64'(err_q.size()), 64'(0));
        summary();
        $finish;
    end
endmodule